// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches two external interrupt pins and turns activity on them into interrupt requests. Each source has an enable and a two-bit sense mode that picks low level, any edge, falling edge or rising edge. Edge modes latch a pending flag that stays set until an acknowledge or a write-one clear. Low-level mode latches nothing: its request follows the synchronised pin and stays up for as long as the pin is held low.

Sensing happens on the pad value that the port actually presents. When the port drives the pin as an output, that driven value is sensed, so software can raise an interrupt by writing the pin. While a source is enabled, the pin's digital input path is forced open even if the port's input gating is off. The synchronised pin value is also returned to the port's read path.

Top module: `ext_irq_sense`

## Requirements
- R1: During and right after reset, every pending flag and every request output is 0. The synchronisers reset to 1.
- R2: Mode 2'b10 (falling edge) sets a source's pending flag on a 1-to-0 change of the pad. The pad is sampled at clock edge k. The flag is still 0 after edge k+1 and is 1 after edge k+2.
- R3: Mode 2'b11 (rising edge) sets the pending flag on a 0-to-1 change of the pad. A 1-to-0 change sets nothing.
- R4: Mode 2'b01 (any edge) sets the pending flag on a change of the pad in either direction. A steady pad sets nothing.
- R5: Mode 2'b00 (low level) latches no flag. The request is 1 while the source is enabled and the synchronised pad is 0, and it drops when the pad returns high.
- R6: A pending flag holds until `flag_ack` or `flag_clr` for that source is 1 at a clock edge. Either one clears it.
- R7: If a new edge is detected in the same cycle as an acknowledge or clear, the flag stays set.
- R8: A disabled source never asserts its request. Its edge flag still latches.
- R9: When `drive_en` is 1, the sensed pad value is `drive_val`, not `pad_in`. Writing `drive_val` therefore triggers the interrupt.
- R10: `pin_read` is the synchronised gated pad. When both `in_gate_en` and the source enable are 0, the gated value is 1. Setting the source enable forces the path open.
- R11: The two sources are independent. Activity on one never sets the other's flag or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | 2 | Raw pad level per source |
| drive_en | input | 2 | Port drives the pin as an output |
| drive_val | input | 2 | Value the port drives |
| in_gate_en | input | 2 | Port digital input enable |
| src_en | input | 2 | Interrupt enable per source |
| src_mode | input | 4 | Sense mode, bits [2i+1:2i] for source i |
| flag_ack | input | 2 | Acknowledge, clears the flag |
| flag_clr | input | 2 | Write-one clear of the flag |
| pin_read | output | 2 | Synchronised pad value for the port read path |
| pend_flag | output | 2 | Pending edge flags |
| irq | output | 2 | Interrupt requests |

## Verification
The bench sets an edge and an acknowledge in the same cycle. A design that lets the clear win would drop the interrupt here, and the flag would read 0. It checks the exact two-edge latency of an edge flag, because a missing or extra sync stage moves the flag by a cycle. It opens the input gate by enabling a source while the gate is off. A design that ignores the enable would return 1 on `pin_read` and never raise the level request. It drives the pin from the output side while the raw pad stays high, which a design sensing `pad_in` directly would miss.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  // Edge qualification: current and previous synchronised samples.
  function automatic logic edge_match(input sense_e m, input logic cur, input logic prev);
    case (m)
      SENSE_ANY:  return cur ^ prev;
      SENSE_FALL: return prev & ~cur;
      SENSE_RISE: return cur & ~prev;
      default:    return 1'b0;
    endcase
  endfunction

  // Level request: active while sampled pin is low in level mode.
  function automatic logic level_match(input sense_e m, input logic cur);
    return (m == SENSE_LOW) && !cur;
  endfunction

  // Pad seen by sensing logic, including gating override.
  function automatic logic gated_pad(input logic pad, input logic drv_en, input logic drv_val,
                                     input logic gate_en, input logic src_en);
    logic eff;
    eff = drv_en ? drv_val : pad;
    return (gate_en | src_en) ? eff : 1'b1;
  endfunction

endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int   WIDTH   = 2,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= {WIDTH{RST_VAL}};
          else        stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= {WIDTH{RST_VAL}};
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_in,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       ack,
  input  logic       clr,
  output logic       flag,
  output logic       irq
);

  sense_e m;
  logic   prev_q;
  logic   flag_q;
  logic   edge_evt;
  logic   clr_evt;
  logic   lvl_mode;
  logic   lvl_req;

  assign m = sense_e'(mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sync_in;
  end

  assign edge_evt = edge_match(m, sync_in, prev_q);
  assign clr_evt  = ack | clr;
  assign lvl_mode = (m == SENSE_LOW);
  assign lvl_req  = level_match(m, sync_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (edge_evt) flag_q <= 1'b1;
    else if (clr_evt)  flag_q <= 1'b0;
  end

  assign flag = flag_q;
  assign irq  = en & (lvl_mode ? lvl_req : flag_q);

  assert_fall_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m == SENSE_FALL) && $fell(sync_in) |=> flag_q);

  assert_rise_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m == SENSE_RISE) && $rose(sync_in) |=> flag_q);

  assert_level_no_latch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_mode && !flag_q |=> !flag_q);

  assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    en && lvl_mode |-> (irq == !sync_in));

  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flag_q && !clr_evt |=> flag_q);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt && !edge_evt |=> !flag_q);

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt && clr_evt |=> flag_q);

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq);

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int N_SRC       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_SRC-1:0]   pad_in,
  input  logic [N_SRC-1:0]   drive_en,
  input  logic [N_SRC-1:0]   drive_val,
  input  logic [N_SRC-1:0]   in_gate_en,
  input  logic [N_SRC-1:0]   src_en,
  input  logic [2*N_SRC-1:0] src_mode,
  input  logic [N_SRC-1:0]   flag_ack,
  input  logic [N_SRC-1:0]   flag_clr,
  output logic [N_SRC-1:0]   pin_read,
  output logic [N_SRC-1:0]   pend_flag,
  output logic [N_SRC-1:0]   irq
);

  localparam int MODE_W = 2;

  logic [N_SRC-1:0] gated;
  logic [N_SRC-1:0] synced;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_gate
      assign gated[i] = gated_pad(pad_in[i], drive_en[i], drive_val[i],
                                  in_gate_en[i], src_en[i]);
    end
  endgenerate

  ext_irq_sync #(
    .WIDTH  (N_SRC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(1'b1)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (gated),
    .q    (synced)
  );

  assign pin_read = synced;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      ext_irq_detect u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_in(synced[i]),
        .en     (src_en[i]),
        .mode   (src_mode[MODE_W*i +: MODE_W]),
        .ack    (flag_ack[i]),
        .clr    (flag_clr[i]),
        .flag   (pend_flag[i]),
        .irq    (irq[i])
      );

      // R10: a closed gate on a disabled source presents 1 to the synchroniser
      assert_gate_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_gate_en[i] && !src_en[i] |-> gated[i]);
    end
  endgenerate

endmodule

// File: tb/ext_irq_sense_tb.sv
`timescale 1ns/1ps
module ext_irq_sense_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pad_in = 2'b11;
  logic [1:0] drive_en = 2'b00;
  logic [1:0] drive_val = 2'b00;
  logic [1:0] in_gate_en = 2'b11;
  logic [1:0] src_en = 2'b00;
  logic [3:0] src_mode = 4'b1010;
  logic [1:0] flag_ack = 2'b00;
  logic [1:0] flag_clr = 2'b00;
  logic [1:0] pin_read, pend_flag, irq;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .drive_en(drive_en),
    .drive_val(drive_val), .in_gate_en(in_gate_en), .src_en(src_en),
    .src_mode(src_mode), .flag_ack(flag_ack), .flag_clr(flag_clr),
    .pin_read(pin_read), .pend_flag(pend_flag), .irq(irq)
  );

  // Vector: [7:6] mode, [5] en, [4] pad before, [3] pad after,
  //         [2] expected flag, [1] expected irq, [0] source
  localparam int NV = 14;
  localparam logic [7:0] VEC [NV] = '{
    {2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'b11, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    {2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    {2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {2'b11, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'b10, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic string vec_tag(input logic [1:0] mode, input logic en);
    if (!en) return "R8";
    case (mode)
      2'b10:   return "R2";
      2'b11:   return "R3";
      2'b01:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic clear_flag(input int s);
    flag_clr[s] = 1'b1;
    tick(1);
    flag_clr[s] = 1'b0;
  endtask

  initial begin
    tick(3);
    chk("R1", "flag in reset", pend_flag, 2'b00);
    chk("R1", "irq in reset", irq, 2'b00);
    rst_n = 1'b1;
    tick(1);
    chk("R1", "flag after reset", pend_flag, 2'b00);
    chk("R1", "pin_read after reset", pin_read, 2'b11);

    // table walk
    for (int v = 0; v < NV; v++) begin
      automatic int s = int'(VEC[v][0]);
      src_en[s] = 1'b0;
      src_mode[2*s +: 2] = VEC[v][7:6];
      pad_in[s] = VEC[v][4];
      tick(4);
      clear_flag(s);
      src_en[s] = VEC[v][5];
      pad_in[s] = VEC[v][3];
      tick(4);
      chk(vec_tag(VEC[v][7:6], VEC[v][5]), $sformatf("vec %0d flag", v),
          pend_flag[s], VEC[v][2]);
      chk(vec_tag(VEC[v][7:6], VEC[v][5]), $sformatf("vec %0d irq", v),
          irq[s], VEC[v][1]);
      chk("R11", $sformatf("vec %0d other flag", v), pend_flag[1-s], 1'b0);
      src_en[s] = 1'b0;
      pad_in[s] = 1'b1;
      tick(4);
      clear_flag(s);
    end

    // R2 exact latency, falling on source 0
    src_mode = 4'b1010;
    src_en = 2'b11;
    pad_in = 2'b11;
    tick(4);
    clear_flag(0);
    clear_flag(1);
    pad_in[0] = 1'b0;
    tick(2);
    chk("R2", "flag one edge early", pend_flag[0], 1'b0);
    tick(1);
    chk("R2", "flag on time", pend_flag[0], 1'b1);
    chk("R11", "source 1 untouched", {pend_flag[1], irq[1]}, 2'b00);

    // R6 hold and clear paths
    tick(5);
    chk("R6", "flag holds", pend_flag[0], 1'b1);
    flag_ack[0] = 1'b1;
    tick(1);
    flag_ack[0] = 1'b0;
    chk("R6", "ack clears", pend_flag[0], 1'b0);
    pad_in[0] = 1'b1;
    tick(4);
    pad_in[0] = 1'b0;
    tick(4);
    chk("R6", "flag set again", pend_flag[0], 1'b1);
    clear_flag(0);
    chk("R6", "clear clears", pend_flag[0], 1'b0);

    // R7 edge and ack in the same cycle (any-edge mode)
    src_mode[1:0] = 2'b01;
    pad_in[0] = 1'b1;
    tick(4);
    chk("R7", "setup flag", pend_flag[0], 1'b1);
    pad_in[0] = 1'b0;
    tick(2);
    flag_ack[0] = 1'b1;
    tick(1);
    flag_ack[0] = 1'b0;
    chk("R7", "edge beats ack", pend_flag[0], 1'b1);
    flag_ack[0] = 1'b1;
    tick(1);
    flag_ack[0] = 1'b0;
    chk("R7", "later ack clears", pend_flag[0], 1'b0);

    // R9 software trigger through the output driver
    src_mode[1:0] = 2'b10;
    pad_in[0] = 1'b1;
    drive_en[0] = 1'b1;
    drive_val[0] = 1'b1;
    tick(4);
    clear_flag(0);
    drive_val[0] = 1'b0;
    tick(4);
    chk("R9", "driven low sets flag", pend_flag[0], 1'b1);
    chk("R9", "driven low irq", irq[0], 1'b1);
    chk("R9", "pin_read shows driven", pin_read[0], 1'b0);
    drive_en[0] = 1'b0;
    tick(4);
    clear_flag(0);

    // R10 gating forced open by the enable
    src_en[1] = 1'b0;
    src_mode[3:2] = 2'b00;
    in_gate_en[1] = 1'b0;
    pad_in[1] = 1'b0;
    tick(4);
    chk("R10", "gated closed reads 1", pin_read[1], 1'b1);
    chk("R10", "no irq while disabled", irq[1], 1'b0);
    src_en[1] = 1'b1;
    tick(3);
    chk("R10", "enable opens path", pin_read[1], 1'b0);
    chk("R10", "level irq via forced path", irq[1], 1'b1);
    pad_in[1] = 1'b1;
    tick(3);
    chk("R5", "level irq drops", irq[1], 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

endmodule